// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank with Frame-Aligned Commit

This block holds the configuration words that a display pipeline consumes. Each word exists twice. The shadow copy is what software writes. The active copy is what drives the datapath through a wide parallel output. Software stages a full set of changes in the shadow copy, then raises a load request. The controller copies the whole shadow bank into the active bank in one clock edge, at the next vertical blanking strobe. The datapath therefore never sees a partly updated frame setup.

A control word holds three bits: a load request, an automatic-reload disable, and a wipe command that zeros the shadow bank. The load request reads back as set until the copy has happened, so software can poll it before starting the next batch. When automatic reload is enabled, every blanking strobe copies the bank without any request. Reads at the configuration offsets return shadow values. A second window at other offsets returns the active values for debug.

A two-state machine tracks the commit. In `ST_IDLE` no load is outstanding. The transition *arm* (a load request written with no blanking strobe in that cycle) leads to `ST_ARMED`. The transition *commit* (a blanking strobe while armed) copies the bank and returns to `ST_IDLE`. A load request that arrives together with a strobe takes the transition *direct commit*, which copies the bank and stays in `ST_IDLE`.

Top module: `shadow_commit_ctrl`

## Requirements
- R1: After reset, every shadow and active word is zero, the pending flag is 0, and the control word reads 0x2. Control bits: bit0 is load pending or request, bit1 is automatic-reload disable, and bit2 is wipe, which is write-only and reads 0.
- R2: A write to configuration offset CFG_BASE+4*i updates shadow word i only. A read of that offset returns the shadow value, while the active value (debug offset DBG_BASE+4*i, and the active output) stays unchanged until a copy.
- R3: Writing the control word with bit0=1 and no strobe in that cycle sets the pending flag from the next cycle. The flag stays set until a cycle with vblank high. That strobe copies the bank, and the flag reads 0 from the following cycle.
- R4: While automatic reload is disabled and no load is pending or requested, a vblank strobe leaves every active word unchanged.
- R5: While automatic reload is enabled (bit1=0), every vblank strobe copies the shadow bank to the active bank without any request.
- R6: A load request written in the same cycle as a vblank strobe completes on that strobe: the active bank equals the shadow bank afterwards, and the pending flag never reads 1.
- R7: Writing the control word with bit2=1 zeros every shadow word in one cycle. The active words keep their values until the next copy.
- R8: Active words change only in the cycle after a vblank strobe, and all words change together on the same edge.
- R9: Writes to offsets that are neither the control word nor a configuration word change nothing, and reads of such offsets return 0. Address bits [1:0] are ignored.
- R10: A shadow write in the same cycle as a copying strobe makes the active word take the value from before the write. The new value stays in the shadow word for the next copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Byte address of the combinational read |
| rd_data | output | DATA_W | Read data |
| vblank | input | 1 | One-cycle vertical blanking strobe |
| load_pending | output | 1 | Load requested and not yet copied |
| active_cfg | output | NUM_CFG*DATA_W | Active words, word i at bits [i*DATA_W +: DATA_W] |

## Verification
Two pairs of events can land in the same cycle, and both are provoked on purpose by driving the inputs together. The first pair is a load-request write and the blanking strobe. Here the outcome is judged by the active bank matching the shadow bank one cycle later, with the pending flag never observed high. The second pair is a shadow write and a copying strobe under automatic reload. Here the active word must hold the earlier shadow value while the shadow read already shows the new one, and a later strobe must deliver the new value.

// File: rtl/shadow_commit_pkg.sv
`timescale 1ns/1ps
package shadow_commit_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } commit_state_e;

    localparam int CTRL_LOAD_BIT    = 0;
    localparam int CTRL_AUTOOFF_BIT = 1;
    localparam int CTRL_WIPE_BIT    = 2;
endpackage

// File: rtl/commit_fsm.sv
`timescale 1ns/1ps
module commit_fsm
    import shadow_commit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic req_bit,
    input  logic autooff_bit,
    input  logic vblank,
    output logic copy_en,
    output logic pending,
    output logic autoload_off
);
    commit_state_e state, state_nx;
    logic          load_req;

    assign load_req = ctrl_wr & req_bit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            autoload_off <= 1'b1;
        end else begin
            state <= state_nx;
            if (ctrl_wr) begin
                autoload_off <= autooff_bit;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (load_req && !vblank) state_nx = ST_ARMED;
            ST_ARMED: if (vblank)              state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        pending = (state == ST_ARMED);
        copy_en = vblank && ((state == ST_ARMED) || load_req || !autoload_off);
    end

    assert_pending_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !vblank) |=> pending);
    assert_pending_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && vblank) |=> !pending);
    assert_same_cycle_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && vblank) |=> !pending);
endmodule

// File: rtl/shadow_bank.sv
`timescale 1ns/1ps
module shadow_bank #(
    parameter int NUM_CFG = 8,
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_hit,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      wipe,
    input  logic                      copy_en,
    output logic [NUM_CFG*DATA_W-1:0] shadow_flat,
    output logic [NUM_CFG*DATA_W-1:0] active_flat
);
    for (genvar g = 0; g < NUM_CFG; g++) begin : g_word
        logic [DATA_W-1:0] shadow_q, active_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q <= '0;
            end else if (wipe) begin
                shadow_q <= '0;
            end else if (wr_hit && (wr_idx == IDX_W'(g))) begin
                shadow_q <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                active_q <= '0;
            end else if (copy_en) begin
                active_q <= shadow_q;
            end
        end

        assign shadow_flat[g*DATA_W +: DATA_W] = shadow_q;
        assign active_flat[g*DATA_W +: DATA_W] = active_q;
    end

    assert_wipe_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (shadow_flat == '0));
endmodule

// File: rtl/read_mux.sv
`timescale 1ns/1ps
module read_mux #(
    parameter int NUM_CFG  = 8,
    parameter int DATA_W   = 32,
    parameter int WORD_W   = 6,
    parameter int IDX_W    = 3,
    parameter int CFG_WORD = 16,
    parameter int DBG_WORD = 32
) (
    input  logic [WORD_W-1:0]         rd_word,
    input  logic [NUM_CFG*DATA_W-1:0] shadow_flat,
    input  logic [NUM_CFG*DATA_W-1:0] active_flat,
    input  logic                      pending,
    input  logic                      autoload_off,
    output logic [DATA_W-1:0]         rd_data
);
    localparam logic [WORD_W-1:0] CFG_W = WORD_W'(CFG_WORD);
    localparam logic [WORD_W-1:0] DBG_W = WORD_W'(DBG_WORD);
    localparam logic [WORD_W-1:0] CNT_W = WORD_W'(NUM_CFG);

    logic [WORD_W-1:0] cfg_off, dbg_off;
    logic              cfg_hit, dbg_hit;

    always_comb begin
        cfg_off = rd_word - CFG_W;
        dbg_off = rd_word - DBG_W;
        cfg_hit = (rd_word >= CFG_W) && (cfg_off < CNT_W);
        dbg_hit = (rd_word >= DBG_W) && (dbg_off < CNT_W);
        rd_data = '0;
        if (rd_word == '0) begin
            rd_data[1:0] = {autoload_off, pending};
        end else if (cfg_hit) begin
            rd_data = shadow_flat[int'(cfg_off[IDX_W-1:0])*DATA_W +: DATA_W];
        end else if (dbg_hit) begin
            rd_data = active_flat[int'(dbg_off[IDX_W-1:0])*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/shadow_commit_ctrl.sv
`timescale 1ns/1ps
module shadow_commit_ctrl
    import shadow_commit_pkg::*;
#(
    parameter int NUM_CFG  = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int CFG_BASE = 'h40,
    parameter int DBG_BASE = 'h80
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DATA_W-1:0]         rd_data,
    input  logic                      vblank,
    output logic                      load_pending,
    output logic [NUM_CFG*DATA_W-1:0] active_cfg
);
    localparam int WORD_W   = ADDR_W - 2;
    localparam int IDX_W    = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;
    localparam int CFG_WORD = CFG_BASE / 4;
    localparam int DBG_WORD = DBG_BASE / 4;
    localparam logic [WORD_W-1:0] CFG_W = WORD_W'(CFG_WORD);
    localparam logic [WORD_W-1:0] CNT_W = WORD_W'(NUM_CFG);

    logic [WORD_W-1:0]         wr_word, wr_off;
    logic                      ctrl_wr, cfg_wr, wipe;
    logic                      copy_en, autoload_off;
    logic [NUM_CFG*DATA_W-1:0] shadow_flat;

    always_comb begin
        wr_word = wr_addr[ADDR_W-1:2];
        wr_off  = wr_word - CFG_W;
        ctrl_wr = wr_en && (wr_word == '0);
        cfg_wr  = wr_en && (wr_word >= CFG_W) && (wr_off < CNT_W);
        wipe    = ctrl_wr && wr_data[CTRL_WIPE_BIT];
    end

    commit_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (ctrl_wr),
        .req_bit      (wr_data[CTRL_LOAD_BIT]),
        .autooff_bit  (wr_data[CTRL_AUTOOFF_BIT]),
        .vblank       (vblank),
        .copy_en      (copy_en),
        .pending      (load_pending),
        .autoload_off (autoload_off)
    );

    shadow_bank #(.NUM_CFG(NUM_CFG), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_hit      (cfg_wr),
        .wr_idx      (wr_off[IDX_W-1:0]),
        .wr_data     (wr_data),
        .wipe        (wipe),
        .copy_en     (copy_en),
        .shadow_flat (shadow_flat),
        .active_flat (active_cfg)
    );

    read_mux #(
        .NUM_CFG(NUM_CFG), .DATA_W(DATA_W), .WORD_W(WORD_W),
        .IDX_W(IDX_W), .CFG_WORD(CFG_WORD), .DBG_WORD(DBG_WORD)
    ) u_rd (
        .rd_word      (rd_addr[ADDR_W-1:2]),
        .shadow_flat  (shadow_flat),
        .active_flat  (active_cfg),
        .pending      (load_pending),
        .autoload_off (autoload_off),
        .rd_data      (rd_data)
    );

    assert_active_only_on_vblank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_cfg) |-> $past(vblank));
    assert_no_autoload_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank && autoload_off && !load_pending && !(ctrl_wr && wr_data[CTRL_LOAD_BIT]))
        |=> $stable(active_cfg));
endmodule

// File: tb/shadow_commit_ctrl_bench.sv
`timescale 1ns/1ps
module shadow_commit_ctrl_bench;
    localparam int N    = 8;
    localparam int DW   = 32;
    localparam int AW   = 8;
    localparam int CFGB = 'h40;
    localparam int DBGB = 'h80;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          vblank = 1'b0;
    logic          load_pending;
    logic [N*DW-1:0] active_cfg;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] exp_sh [N];
    logic [DW-1:0] exp_ac [N];

    always #2 clk = ~clk;

    shadow_commit_ctrl u_shadow_commit_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .vblank(vblank), .load_pending(load_pending), .active_cfg(active_cfg)
    );

    function automatic logic [DW-1:0] pat(input int k, input int i);
        return DW'(32'h1000_0000 * k + 32'h0102_0304 * (i + 1) + k * i);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d);
        rd_addr = AW'(a);
        #0.5;
        d = rd_data;
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse();
        vblank = 1'b1;
        step();
        vblank = 1'b0;
    endtask

    task automatic check_bank(input string req);
        logic [DW-1:0] d;
        for (int i = 0; i < N; i++) begin
            rd(CFGB + 4*i, d);
            chk(d == exp_sh[i], req, d, exp_sh[i]);
            rd(DBGB + 4*i, d);
            chk(d == exp_ac[i], req, d, exp_ac[i]);
            chk(active_cfg[i*DW +: DW] == exp_ac[i], req, active_cfg[i*DW +: DW], exp_ac[i]);
        end
    endtask

    task automatic copy_model();
        for (int i = 0; i < N; i++) exp_ac[i] = exp_sh[i];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        for (int i = 0; i < N; i++) begin exp_sh[i] = '0; exp_ac[i] = '0; end
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        rd(0, d);
        chk(d == 32'h2, "R1", d, 32'h2);
        chk(load_pending == 1'b0, "R1", {31'b0, load_pending}, 32'h0);
        check_bank("R1");

        for (int k = 1; k <= 3; k++) begin
            // R2: staged writes stay in shadow
            for (int i = 0; i < N; i++) begin
                wr(CFGB + 4*i, pat(k, i));
                exp_sh[i] = pat(k, i);
            end
            check_bank("R2");
            // R4: strobe without request leaves active alone
            pulse();
            check_bank("R4");
            // R3: request, pending holds, strobe copies
            wr(0, 32'h3);
            rd(0, d);
            chk(d == 32'h3, "R3", d, 32'h3);
            for (int w = 0; w < k + 1; w++) begin
                step();
                chk(load_pending == 1'b1, "R3", {31'b0, load_pending}, 32'h1);
            end
            check_bank("R3");
            pulse();
            copy_model();
            chk(load_pending == 1'b0, "R3", {31'b0, load_pending}, 32'h0);
            check_bank("R8");
        end

        // R6: request and strobe together
        for (int i = 0; i < N; i++) begin
            wr(CFGB + 4*i, pat(4, i));
            exp_sh[i] = pat(4, i);
        end
        wr_en = 1'b1; wr_addr = '0; wr_data = 32'h3; vblank = 1'b1;
        step();
        wr_en = 1'b0; vblank = 1'b0;
        copy_model();
        chk(load_pending == 1'b0, "R6", {31'b0, load_pending}, 32'h0);
        check_bank("R6");

        // R7: wipe clears shadow, active kept until copy
        wr(0, 32'h6);
        for (int i = 0; i < N; i++) exp_sh[i] = '0;
        check_bank("R7");
        wr(0, 32'h3);
        pulse();
        copy_model();
        check_bank("R7");

        // R5: automatic reload copies each strobe
        wr(0, 32'h0);
        rd(0, d);
        chk(d == 32'h0, "R5", d, 32'h0);
        for (int k = 5; k <= 6; k++) begin
            for (int i = 0; i < N; i++) begin
                wr(CFGB + 4*i, pat(k, i));
                exp_sh[i] = pat(k, i);
            end
            pulse();
            copy_model();
            check_bank("R5");
        end

        // R10: shadow write coinciding with a copying strobe
        for (int i = 0; i < N; i++) begin
            wr_en = 1'b1; wr_addr = AW'(CFGB + 4*i); wr_data = pat(7, i); vblank = 1'b1;
            step();
            wr_en = 1'b0; vblank = 1'b0;
            copy_model();
            exp_sh[i] = pat(7, i);
            check_bank("R10");
        end
        pulse();
        copy_model();
        check_bank("R10");

        // R9: unmapped offsets and ignored low address bits
        for (int a = 1; a < 64; a++) begin
            if (!((a >= CFGB/4 && a < CFGB/4 + N) || (a >= DBGB/4 && a < DBGB/4 + N))) begin
                wr(4*a, 32'hDEAD_BEEF);
                rd(4*a, d);
                chk(d == 32'h0, "R9", d, 32'h0);
            end
        end
        check_bank("R9");
        wr(CFGB + 4*2 + 3, 32'h0BAD_F00D);
        exp_sh[2] = 32'h0BAD_F00D;
        rd(CFGB + 4*2 + 1, d);
        chk(d == 32'h0BAD_F00D, "R9", d, 32'h0BAD_F00D);
        check_bank("R9");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule